// File: doc/BRIEF.md
# Cache Line Refill Unit

This unit refills one whole cache line after a load misses in a write-through data cache. The cache lookup raises a one-cycle miss pulse with the word address. The unit then requests a burst from memory at the line's base address. It collects the returned words in a staging buffer with one slot and one valid flag per word. Once every slot is full, it writes the complete line into the data array in a single cycle, but only in a cycle when the core is not using the cache.

The word the core asked for is passed straight to the core in the cycle it comes back from memory. The stall for that load then drops, and later loads that hit keep running while the rest of the line arrives. A miss that arrives while a refill is still open is parked. The pipeline stays stalled until the open refill has been committed, the parked refill has been started, and its requested word has been delivered. For as long as the unit holds the memory bus, it signals the store buffer to yield, so a refill goes ahead of buffered stores.

Top module: `line_refill_unit`

## Requirements
- R1: After reset, `stall`, `memReq`, `fillWe`, `fwdValid` and `storeYield` are all low.
- R2: A miss accepted while the unit is idle raises `memReq` in the next cycle. `memAddr` then carries the miss address with its two low bits cleared, and `stall` is high. `memReq` and `memAddr` hold until `memGnt` is seen.
- R3: Beats are stored in arrival order, and the n-th beat (n = 0 to 3) counts as word n above the line base. On `fillData`, word n sits at bits [32n+31:32n].
- R4: `fillWe` pulses for exactly one cycle, and only after all four beats of the burst have arrived. With it, `fillLine` equals the miss address shifted right by two.
- R5: `fillWe` is never high in a cycle with `coreAccess` high. A complete line waits in the buffer until the first cycle with `coreAccess` low.
- R6: When the beat whose index equals the low two bits of the miss address arrives, `fwdValid` is high in that same cycle and `fwdData` equals that beat. `stall` is low from the next cycle.
- R7: Once the requested word has been forwarded, `stall` stays low for the rest of the refill while `coreAccess` is high, as long as no new miss arrives.
- R8: A miss during an open refill raises `stall` from the next cycle. No new `memReq` is issued until the open line has been written. The parked miss's request then starts in the cycle after that write, and `stall` holds until its requested word is forwarded.
- R9: `storeYield` is high in every cycle in which `memReq` is high or a burst is still being received.
- R10: A miss that arrives in the same cycle as the `fillWe` pulse, with nothing parked, starts its own request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | One-cycle pulse: a load missed in the cache |
| missAddr | input | 16 | Word address of the missing load |
| coreAccess | input | 1 | The core uses the cache array this cycle |
| memReq | output | 1 | Burst read request to memory |
| memAddr | output | 16 | Line-aligned burst start address |
| memGnt | input | 1 | Memory accepts the request |
| memRdValid | input | 1 | A burst beat is present on memRdData |
| memRdData | input | 32 | Burst beat data |
| fillWe | output | 1 | Write the whole line into the data array |
| fillLine | output | 14 | Line index for the array write |
| fillData | output | 128 | Complete line, word 0 in the low bits |
| fwdValid | output | 1 | Requested word is on fwdData |
| fwdData | output | 32 | Word forwarded to the core |
| stall | output | 1 | Hold the pipeline |
| storeYield | output | 1 | Store buffer must leave the bus to the refill |

## Verification
The bound checker watches several rules on every cycle:
- the line write never collides with a core access;
- the line write is a lone pulse that comes only after a full four-beat burst counted from the grant;
- a waiting request keeps its aligned address steady;
- the store buffer is told to yield whenever a request is out;
- the stall drops after a forward.

Only the bench scenarios can show the rest. Those are the order of words in the committed line, the choice of the forwarded beat from the miss offset, and how long the commit is held under a busy core. They also cover the parking of a second miss and its later start, and a miss that lands exactly in the commit cycle.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_FILL,
    ST_HOLD
  } fillState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startMiss;  // open a refill for the address on missAddr
    logic startPend;  // open a refill for the parked address
    logic loadPend;   // park missAddr
    logic capture;    // store the current beat
  } dpStrobe_t;

endpackage

// File: rtl/refill_datapath.sv
module refill_datapath
  import refill_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int OFF_W = $clog2(WORDS),
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic [ADDR_W-1:0]       missAddr,
  input  logic [DATA_W-1:0]       memRdData,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [LINE_W-1:0]       fillLine,
  output logic [WORDS*DATA_W-1:0] fillData,
  output logic [DATA_W-1:0]       fwdData,
  output logic                    allValid,
  output logic                    lastBeat,
  output logic                    critBeat
);

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] pendAddr;
  logic [OFF_W-1:0]  beatIdx;
  logic [WORDS-1:0]  wordVld;
  logic [DATA_W-1:0] wordBuf [WORDS];
  logic              startAny;

  assign startAny = strobe.startMiss | strobe.startPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      pendAddr <= '0;
      beatIdx  <= '0;
    end else begin
      if (strobe.startMiss)      curAddr <= missAddr;
      else if (strobe.startPend) curAddr <= pendAddr;
      if (strobe.loadPend)       pendAddr <= missAddr;
      if (startAny)              beatIdx <= '0;
      else if (strobe.capture)   beatIdx <= beatIdx + 1'b1;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wordVld[w] <= 1'b0;
        wordBuf[w] <= '0;
      end else if (startAny) begin
        wordVld[w] <= 1'b0;
      end else if (strobe.capture && beatIdx == OFF_W'(w)) begin
        wordVld[w] <= 1'b1;
        wordBuf[w] <= memRdData;
      end
    end
    assign fillData[w*DATA_W +: DATA_W] = wordBuf[w];
  end

  assign memAddr  = {curAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign fillLine = curAddr[ADDR_W-1:OFF_W];
  assign fwdData  = memRdData;
  assign allValid = &wordVld;
  assign lastBeat = (beatIdx == OFF_W'(WORDS - 1));
  assign critBeat = (beatIdx == curAddr[OFF_W-1:0]);

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      missValid,
  input  logic      coreAccess,
  input  logic      memGnt,
  input  logic      memRdValid,
  input  logic      allValid,
  input  logic      lastBeat,
  input  logic      critBeat,
  output dpStrobe_t strobe,
  output logic      memReq,
  output logic      fillWe,
  output logic      fwdValid,
  output logic      stall,
  output logic      storeYield
);

  fillState_t state, stateNxt;
  logic pendValid;
  logic waitReg;
  logic commit;

  always_comb begin
    commit           = (state == ST_HOLD) && allValid && !coreAccess;
    strobe.startMiss = missValid && ((state == ST_IDLE) || (commit && !pendValid));
    strobe.startPend = commit && pendValid;
    strobe.loadPend  = missValid && !strobe.startMiss;
    strobe.capture   = (state == ST_FILL) && memRdValid;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (strobe.startMiss) stateNxt = ST_REQ;
      ST_REQ:  if (memGnt) stateNxt = ST_FILL;
      ST_FILL: if (strobe.capture && lastBeat) stateNxt = ST_HOLD;
      ST_HOLD: if (commit)
                 stateNxt = (strobe.startMiss || strobe.startPend) ? ST_REQ : ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendValid <= 1'b0;
      waitReg   <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strobe.loadPend)       pendValid <= 1'b1;
      else if (strobe.startPend) pendValid <= 1'b0;
      if (missValid)             waitReg <= 1'b1;
      else if (fwdValid)         waitReg <= 1'b0;
    end
  end

  assign memReq     = (state == ST_REQ);
  assign fillWe     = commit;
  assign fwdValid   = strobe.capture && critBeat;
  assign stall      = waitReg;
  assign storeYield = (state == ST_REQ) || (state == ST_FILL);

endmodule

// File: rtl/line_refill_unit.sv
module line_refill_unit
  import refill_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int OFF_W = $clog2(WORDS),
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    missValid,
  input  logic [ADDR_W-1:0]       missAddr,
  input  logic                    coreAccess,
  output logic                    memReq,
  output logic [ADDR_W-1:0]       memAddr,
  input  logic                    memGnt,
  input  logic                    memRdValid,
  input  logic [DATA_W-1:0]       memRdData,
  output logic                    fillWe,
  output logic [LINE_W-1:0]       fillLine,
  output logic [WORDS*DATA_W-1:0] fillData,
  output logic                    fwdValid,
  output logic [DATA_W-1:0]       fwdData,
  output logic                    stall,
  output logic                    storeYield
);

  dpStrobe_t strobe;
  logic allValid, lastBeat, critBeat;

  refill_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .missValid (missValid),
    .coreAccess(coreAccess),
    .memGnt    (memGnt),
    .memRdValid(memRdValid),
    .allValid  (allValid),
    .lastBeat  (lastBeat),
    .critBeat  (critBeat),
    .strobe    (strobe),
    .memReq    (memReq),
    .fillWe    (fillWe),
    .fwdValid  (fwdValid),
    .stall     (stall),
    .storeYield(storeYield)
  );

  refill_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .WORDS (WORDS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .missAddr (missAddr),
    .memRdData(memRdData),
    .memAddr  (memAddr),
    .fillLine (fillLine),
    .fillData (fillData),
    .fwdData  (fwdData),
    .allValid (allValid),
    .lastBeat (lastBeat),
    .critBeat (critBeat)
  );

endmodule

// File: rtl/line_refill_chk.sv
module line_refill_chk #(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 4,
  localparam int OFF_W = $clog2(WORDS),
  localparam int CNT_W = $clog2(WORDS + 1) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic              coreAccess,
  input logic              memReq,
  input logic              memGnt,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdValid,
  input logic              fillWe,
  input logic              fwdValid,
  input logic              stall,
  input logic              storeYield
);

  logic [CNT_W-1:0] beatCnt;

  always_ff @(posedge clk) begin
    if (!rstN) beatCnt <= '0;
    else if (memReq && memGnt) beatCnt <= '0;
    else if (memRdValid) beatCnt <= beatCnt + 1'b1;
  end

  // R5
  fill_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillWe |-> !coreAccess);

  // R4
  fill_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillWe |=> !fillWe);

  // R4
  fill_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillWe |-> beatCnt == CNT_W'(WORDS));

  // R2
  req_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[OFF_W-1:0] == '0);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr));

  // R9
  yield_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> storeYield);

  // R6
  fwd_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid && !missValid |=> !stall);

endmodule

bind line_refill_unit line_refill_chk #(
  .ADDR_W(ADDR_W),
  .WORDS (WORDS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .missValid (missValid),
  .coreAccess(coreAccess),
  .memReq    (memReq),
  .memGnt    (memGnt),
  .memAddr   (memAddr),
  .memRdValid(memRdValid),
  .fillWe    (fillWe),
  .fwdValid  (fwdValid),
  .stall     (stall),
  .storeYield(storeYield)
);

// File: tb/line_refill_unit_tb.sv
module line_refill_unit_tb;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NW = 4;
  localparam int LW = AW - 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0;
  logic [AW-1:0] missAddr = '0;
  logic coreAccess = 1'b0;
  logic memReq;
  logic [AW-1:0] memAddr;
  logic memGnt = 1'b0;
  logic memRdValid = 1'b0;
  logic [DW-1:0] memRdData = '0;
  logic fillWe;
  logic [LW-1:0] fillLine;
  logic [NW*DW-1:0] fillData;
  logic fwdValid;
  logic [DW-1:0] fwdData;
  logic stall;
  logic storeYield;

  int nChk = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  line_refill_unit u_dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .coreAccess(coreAccess), .memReq(memReq), .memAddr(memAddr), .memGnt(memGnt),
    .memRdValid(memRdValid), .memRdData(memRdData), .fillWe(fillWe),
    .fillLine(fillLine), .fillData(fillData), .fwdValid(fwdValid),
    .fwdData(fwdData), .stall(stall), .storeYield(storeYield)
  );

  // {missAddr, grant delay, busy cycles before commit}
  localparam logic [31:0] VEC [6] = '{
    {16'h0040, 8'd0, 8'd0},
    {16'h0125, 8'd2, 8'd3},
    {16'h0FFE, 8'd1, 8'd1},
    {16'h8003, 8'd0, 8'd5},
    {16'hFFFF, 8'd3, 8'd0},
    {16'h0211, 8'd0, 8'd2}
  };

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] base, input int i);
    return 32'hA500_0000 ^ {8'h00, base, 8'h00} ^ 32'(i);
  endfunction

  function automatic logic [NW*DW-1:0] lineOf(input logic [AW-1:0] base);
    return {pat(base, 3), pat(base, 2), pat(base, 1), pat(base, 0)};
  endfunction

  function automatic logic [AW-1:0] baseOf(input logic [AW-1:0] a);
    return {a[AW-1:2], 2'b00};
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  // miss from idle; returns inside the first request cycle
  task automatic startMiss(input logic [AW-1:0] a);
    cyc();
    missValid = 1'b1;
    missAddr  = a;
    #1;
    check(stall == 1'b0, "R2 stall before miss", 128'(stall), 0);
    cyc();
    missValid = 1'b0;
    #1;
    check(memReq == 1'b1, "R2 request raised", 128'(memReq), 1);
    check(memAddr == baseOf(a), "R2 aligned address", 128'(memAddr), 128'(baseOf(a)));
    check(stall == 1'b1, "R2 stall on miss", 128'(stall), 1);
    check(storeYield == 1'b1, "R9 yield on request", 128'(storeYield), 1);
  endtask

  task automatic grant(input int d, input logic [AW-1:0] base);
    memGnt = (d == 0);
    for (int k = 1; k <= d; k++) begin
      cyc();
      memGnt = (k == d);
      #1;
      check(memReq == 1'b1 && memAddr == base, "R2 request held",
            128'(memAddr), 128'(base));
      check(storeYield == 1'b1, "R9 yield while waiting", 128'(storeYield), 1);
    end
  endtask

  task automatic beats(input logic [AW-1:0] base, input int off,
                       input int missAt, input logic [AW-1:0] mAddr);
    for (int i = 0; i < NW; i++) begin
      cyc();
      memGnt     = 1'b0;
      coreAccess = 1'b1;
      memRdValid = 1'b1;
      memRdData  = pat(base, i);
      missValid  = (i == missAt);
      missAddr   = mAddr;
      #1;
      check(fwdValid == (i == off), "R6 forward strobe", 128'(fwdValid), 128'(i == off));
      if (i == off)
        check(fwdData == pat(base, i), "R6 forward data", 128'(fwdData), 128'(pat(base, i)));
      check(fillWe == 1'b0, "R4 no write mid burst", 128'(fillWe), 0);
      check(storeYield == 1'b1, "R9 yield during burst", 128'(storeYield), 1);
      if (i > off)
        check(stall == (missAt >= 0 && i > missAt), "R7/R8 stall during refill",
              128'(stall), 128'(missAt >= 0 && i > missAt));
    end
    cyc();
    memRdValid = 1'b0;
    missValid  = 1'b0;
  endtask

  task automatic commit(input int busy, input logic [AW-1:0] base, input bit expStall,
                        input bit doMiss, input logic [AW-1:0] mAddr,
                        input bit expNext, input logic [AW-1:0] nextBase);
    for (int k = 0; k < busy; k++) begin
      coreAccess = 1'b1;
      #1;
      check(fillWe == 1'b0, "R5 write held while busy", 128'(fillWe), 0);
      check(stall == expStall, "R8 stall while held", 128'(stall), 128'(expStall));
      check(memReq == 1'b0, "R8 no request before write", 128'(memReq), 0);
      cyc();
    end
    coreAccess = 1'b0;
    missValid  = doMiss;
    missAddr   = mAddr;
    #1;
    check(fillWe == 1'b1, "R5 write on idle cycle", 128'(fillWe), 1);
    check(fillLine == base[AW-1:2], "R4 line index", 128'(fillLine), 128'(base[AW-1:2]));
    check(fillData == lineOf(base), "R3 line word order", fillData, lineOf(base));
    cyc();
    missValid = 1'b0;
    #1;
    check(fillWe == 1'b0, "R4 single pulse", 128'(fillWe), 0);
    if (expNext) begin
      check(memReq == 1'b1 && memAddr == nextBase, "R8/R10 next request",
            128'(memAddr), 128'(nextBase));
      check(stall == 1'b1, "R8/R10 stall kept", 128'(stall), 1);
    end else begin
      check(memReq == 1'b0, "R4 idle after write", 128'(memReq), 0);
      check(stall == 1'b0, "R7 no stall after write", 128'(stall), 0);
      check(storeYield == 1'b0, "R9 yield released", 128'(storeYield), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    #1;
    check(stall == 1'b0 && memReq == 1'b0 && fillWe == 1'b0, "R1 reset outputs",
          {stall, memReq, fillWe}, 0);
    check(fwdValid == 1'b0 && storeYield == 1'b0, "R1 reset outputs",
          {fwdValid, storeYield}, 0);
    rstN = 1'b1;
    cyc();
    #1;
    check(memReq == 1'b0 && stall == 1'b0, "R1 idle after reset", {memReq, stall}, 0);

    // table walk: single refills with varied offsets, grant delays, busy windows
    for (int v = 0; v < 6; v++) begin
      logic [AW-1:0] a;
      a = VEC[v][31:16];
      startMiss(a);
      grant(int'(VEC[v][15:8]), baseOf(a));
      beats(baseOf(a), int'(a[1:0]), -1, '0);
      commit(int'(VEC[v][7:0]), baseOf(a), 1'b0, 1'b0, '0, 1'b0, '0);
    end

    // R8: second miss parked during a refill
    startMiss(16'h0300);
    grant(1, 16'h0300);
    beats(16'h0300, 0, 2, 16'h0442);
    commit(2, 16'h0300, 1'b1, 1'b0, '0, 1'b1, 16'h0440);
    grant(0, 16'h0440);
    beats(16'h0440, 2, -1, '0);
    commit(0, 16'h0440, 1'b0, 1'b0, '0, 1'b0, '0);

    // R10: miss arriving in the commit cycle
    startMiss(16'h0513);
    grant(0, 16'h0510);
    beats(16'h0510, 3, -1, '0);
    commit(1, 16'h0510, 1'b0, 1'b1, 16'h0620, 1'b1, 16'h0620);
    grant(2, 16'h0620);
    beats(16'h0620, 0, -1, '0);
    commit(0, 16'h0620, 1'b0, 1'b0, '0, 1'b0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule